// File: doc/BRIEF.md
# Boot ROM and Shadow-RAM Address Decoder

This block steers every memory access of a 32-bit physical address space to either a 64 KiB boot ROM or main RAM. After a hardware reset the ROM answers only in the top 64 KiB of the space, so the processor's first fetch, 16 bytes below the top, lands in ROM. Everything else goes to RAM.

Boot firmware then programs a small attribute register in stages. First it opens a second window that shows the ROM in the low 64 KiB at 0x000F0000. In that window, reads come from ROM while writes fall through to RAM, which lets firmware copy ROM onto RAM. Next it switches the window to RAM, so the copy is served from RAM, optionally with writes refused. The top-of-memory ROM window stays live throughout.

An address-line gate input models the legacy wrap: when the gate is closed, bit 20 is cleared before decode, so every window reappears at 1 MiB intervals. Decode results are registered and appear in the cycle after the access is presented.

Top module: `boot_map_decoder`

## Requirements
- R1: After reset the attribute register is all zero. All outputs are low until an access is made, and a read of the low window 0x000F0000–0x000FFFFF is routed to RAM (ram_sel=1, rom_sel=0).
- R2: An access whose effective address lies in 0xFFFF0000–0xFFFFFFFF selects ROM in every attribute state, including the first fetch at 0xFFFFFFF0. 0xFFFEFFFF selects RAM. A write to the ROM window selects ROM and never raises ram_we.
- R3: With a20_en=0, eff_addr equals acc_addr with bit 20 cleared, and decode uses that value: 0xFFFFFFF0 still selects ROM and 0x001F0000 decodes as the low window. With a20_en=1, eff_addr equals acc_addr and 0xFFEF0010 selects RAM.
- R4: Attribute bit 0 (low enable) set with bits 2:1 (mode) = 00: reads in the low window select ROM; writes there select RAM with ram_we=1.
- R5: Low enable set with mode 01: reads and writes in the low window select RAM (ram_we on writes), never ROM, while the top window still selects ROM.
- R6: Low enable set with mode 10 or 11: low-window reads select RAM. Low-window writes raise wr_blocked with ram_sel=0 and ram_we=0.
- R7: Attribute bit 3 (write protect) blocks low-window writes in mode 01 exactly as in R6. In mode 00 it has no effect, and writes still reach RAM.
- R8: rom_sel and ram_sel are never high together. A cycle without acc_valid in the previous cycle leaves rom_sel, ram_sel, ram_we and wr_blocked low, so wr_blocked lasts one cycle per blocked write.
- R9: Any address outside the ROM and low windows selects RAM, with ram_we equal to acc_write. ram_we is only ever high together with ram_sel.
- R10: Results appear one cycle after the access is presented. An attribute write (cfg_we) on the same edge as an access does not affect that access; it governs the access presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Physical address of the access |
| a20_en | input | 1 | 1 = bit 20 passes, 0 = bit 20 forced to zero |
| cfg_we | input | 1 | Attribute register write strobe |
| cfg_wdata | input | 4 | Attribute value: bit3 write protect, bits2:1 mode, bit0 low enable |
| rom_sel | output | 1 | Access goes to ROM |
| ram_sel | output | 1 | Access goes to RAM |
| ram_we | output | 1 | RAM write enable |
| wr_blocked | output | 1 | Write refused by shadow protection |
| eff_addr | output | 32 | Address after bit-20 masking, for the last access |

## Verification
A corrupted attribute register shows up on the very next low-window access, one cycle after it is presented. The symptom is ROM where RAM is expected, a missing ram_we during the copy phase, or a block missing where one is due. A wrong bit-20 mask shows up at once in eff_addr and as a miss on the wrapped top window. The bench therefore probes each attribute state with both a read and a write into the low window and a read of the top window. It also places a configuration write on the same edge as an access, to pin down the one-cycle boundary.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

    // Behaviour of the low window once it is enabled
    typedef enum logic [1:0] {
        LOW_COPY   = 2'b00,   // reads from ROM, writes into RAM
        LOW_RAM_RW = 2'b01,   // RAM for both directions
        LOW_RAM_RO = 2'b10,   // RAM reads, writes refused
        LOW_RAM_R2 = 2'b11    // treated as read-only
    } low_mode_e;

    // Attribute register: bit3 protect, bits2:1 mode, bit0 enable
    typedef struct packed {
        logic      wprot;
        low_mode_e mode;
        logic      low_en;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    typedef struct packed {
        logic rom_sel;
        logic ram_sel;
        logic ram_we;
        logic wr_blocked;
    } route_t;

endpackage

// File: rtl/boot_map_a20.sv
module boot_map_a20 #(
    parameter int ADDR_W    = 32,
    parameter int ALIAS_BIT = 20
) (
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic              gate_open,
    output logic [ADDR_W-1:0] masked_addr
);
    always_comb begin
        masked_addr = raw_addr;
        if (!gate_open) begin
            masked_addr[ALIAS_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/boot_map_region.sv
module boot_map_region #(
    parameter int              ADDR_W      = 32,
    parameter int              REGION_BITS = 16,
    parameter int              ALIAS_BIT   = 20,
    parameter logic [31:0]     LOW_BASE    = 32'h000F_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              gate_open,
    output logic              hit_top,
    output logic              hit_low
);
    localparam int TAG_W    = ADDR_W - REGION_BITS;
    localparam int TAG_ABIT = ALIAS_BIT - REGION_BITS;
    localparam logic [TAG_W-1:0] TOP_TAG = '1;
    localparam logic [TAG_W-1:0] LOW_TAG = LOW_BASE[ADDR_W-1:REGION_BITS];

    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] top_tag_eff;
    logic [TAG_W-1:0] low_tag_eff;

    // Window tags follow the same bit-20 masking as the address,
    // so a closed gate makes each window alias rather than vanish.
    always_comb begin
        tag         = addr[ADDR_W-1:REGION_BITS];
        top_tag_eff = TOP_TAG;
        low_tag_eff = LOW_TAG;
        if (!gate_open) begin
            top_tag_eff[TAG_ABIT] = 1'b0;
            low_tag_eff[TAG_ABIT] = 1'b0;
        end
        hit_top = (tag == top_tag_eff);
        hit_low = (tag == low_tag_eff) && !hit_top;
    end
endmodule

// File: rtl/boot_map_route.sv
module boot_map_route
    import boot_map_pkg::*;
(
    input  logic   valid,
    input  logic   write,
    input  logic   hit_top,
    input  logic   hit_low,
    input  attr_t  attr,
    output route_t route
);
    logic shadowed;
    logic refuse;

    always_comb begin
        shadowed = attr.low_en && (attr.mode != LOW_COPY);
        refuse   = shadowed && (attr.mode[1] || attr.wprot);
        route    = '0;
        if (valid) begin
            if (hit_top) begin
                route.rom_sel = 1'b1;
            end else if (hit_low && attr.low_en) begin
                if (attr.mode == LOW_COPY) begin
                    route.rom_sel = !write;
                    route.ram_sel = write;
                    route.ram_we  = write;
                end else if (write && refuse) begin
                    route.wr_blocked = 1'b1;
                end else begin
                    route.ram_sel = 1'b1;
                    route.ram_we  = write;
                end
            end else begin
                route.ram_sel = 1'b1;
                route.ram_we  = write;
            end
        end
    end
endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
    import boot_map_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          REGION_BITS = 16,
    parameter int          ALIAS_BIT   = 20,
    parameter logic [31:0] LOW_BASE    = 32'h000F_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              a20_en,
    input  logic              cfg_we,
    input  logic [ATTR_W-1:0] cfg_wdata,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic              ram_we,
    output logic              wr_blocked,
    output logic [ADDR_W-1:0] eff_addr
);
    typedef struct packed {
        attr_t             attr;
        route_t            route;
        logic [ADDR_W-1:0] eff;
    } state_t;

    state_t state_d, state_q;

    logic [ADDR_W-1:0] masked;
    logic              hit_top, hit_low;
    route_t            route_n;

    boot_map_a20 #(
        .ADDR_W   (ADDR_W),
        .ALIAS_BIT(ALIAS_BIT)
    ) u_a20 (
        .raw_addr   (acc_addr),
        .gate_open  (a20_en),
        .masked_addr(masked)
    );

    boot_map_region #(
        .ADDR_W     (ADDR_W),
        .REGION_BITS(REGION_BITS),
        .ALIAS_BIT  (ALIAS_BIT),
        .LOW_BASE   (LOW_BASE)
    ) u_region (
        .addr     (masked),
        .gate_open(a20_en),
        .hit_top  (hit_top),
        .hit_low  (hit_low)
    );

    // Decode uses the attribute value held before this edge (R10)
    boot_map_route u_route (
        .valid  (acc_valid),
        .write  (acc_write),
        .hit_top(hit_top),
        .hit_low(hit_low),
        .attr   (state_q.attr),
        .route  (route_n)
    );

    always_comb begin
        state_d       = state_q;
        state_d.route = route_n;
        if (acc_valid) begin
            state_d.eff = masked;
        end
        if (cfg_we) begin
            state_d.attr = attr_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rom_sel    = state_q.route.rom_sel;
    assign ram_sel    = state_q.route.ram_sel;
    assign ram_we     = state_q.route.ram_we;
    assign wr_blocked = state_q.route.wr_blocked;
    assign eff_addr   = state_q.eff;

endmodule

// File: rtl/boot_map_decoder_chk.sv
module boot_map_decoder_chk #(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 16,
    parameter int ALIAS_BIT   = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              a20_en,
    input logic              rom_sel,
    input logic              ram_sel,
    input logic              ram_we,
    input logic              wr_blocked,
    input logic [ADDR_W-1:0] eff_addr
);
    // R8
    excl_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_sel && ram_sel));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rom_sel && !ram_sel && !ram_we && !wr_blocked);

    // R6
    blocked_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> !ram_sel && !ram_we);

    // R9
    we_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_sel);

    // R2
    top_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && a20_en && (&acc_addr[ADDR_W-1:REGION_BITS]) |=> rom_sel && !ram_we);

    // R3
    alias_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !a20_en |=> !eff_addr[ALIAS_BIT]);

    // R6
    blocked_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> !wr_blocked);
endmodule

bind boot_map_decoder boot_map_decoder_chk #(
    .ADDR_W     (ADDR_W),
    .REGION_BITS(REGION_BITS),
    .ALIAS_BIT  (ALIAS_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .a20_en    (a20_en),
    .rom_sel   (rom_sel),
    .ram_sel   (ram_sel),
    .ram_we    (ram_we),
    .wr_blocked(wr_blocked),
    .eff_addr  (eff_addr)
);

// File: tb/boot_map_decoder_bench.sv
module boot_map_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write, a20_en, cfg_we;
    logic [31:0] acc_addr;
    logic [3:0]  cfg_wdata;
    logic        rom_sel, ram_sel, ram_we, wr_blocked;
    logic [31:0] eff_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    boot_map_decoder u_boot_map_decoder (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .a20_en(a20_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rom_sel(rom_sel), .ram_sel(ram_sel), .ram_we(ram_we),
        .wr_blocked(wr_blocked), .eff_addr(eff_addr)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // rom, ram, we, blocked packed as a 4-bit code
    task automatic check_route(input string req, input logic [3:0] exp);
        check(req, {28'd0, rom_sel, ram_sel, ram_we, wr_blocked}, {28'd0, exp});
    endtask

    // Present one access (optionally with an attribute write) for one cycle,
    // then sample the registered result just after the edge.
    task automatic access(input logic [31:0] a, input logic wr, input logic gate,
                          input logic cw, input logic [3:0] cv);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; a20_en = gate;
        cfg_we = cw; cfg_wdata = cv;
        @(posedge clk); #1;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; cfg_we = 1'b0;
    endtask

    // access() returns at a negedge; results were latched on the prior edge
    task automatic set_attr(input logic [3:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        check_route("R1 reset outputs", 4'b0000);
        access(32'h000F_FFF0, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R1 low read after reset", 4'b0100);
    endtask

    task automatic t_top_rom();
        access(32'hFFFF_FFF0, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R2 first fetch", 4'b1000);
        access(32'hFFFF_0000, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R2 window base", 4'b1000);
        access(32'hFFFE_FFFF, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R2 below window", 4'b0100);
        access(32'hFFFF_1234, 1'b1, 1'b1, 1'b0, 4'h0);
        check_route("R2 write to rom", 4'b1000);
    endtask

    task automatic t_a20();
        access(32'hFFFF_FFF0, 1'b0, 1'b0, 1'b0, 4'h0);
        check_route("R3 gated fetch route", 4'b1000);
        check("R3 gated fetch addr", eff_addr, 32'hFFEF_FFF0);
        access(32'hFFEF_0010, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R3 open gate no alias", 4'b0100);
        check("R3 open gate addr", eff_addr, 32'hFFEF_0010);
        access(32'h0010_0000, 1'b0, 1'b0, 1'b0, 4'h0);
        check("R3 wrap to zero", eff_addr, 32'h0000_0000);
    endtask

    task automatic t_copy();
        set_attr(4'b0001);
        access(32'h000F_0100, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R4 copy read", 4'b1000);
        access(32'h000F_0100, 1'b1, 1'b1, 1'b0, 4'h0);
        check_route("R4 copy write", 4'b0110);
        access(32'h001F_0000, 1'b0, 1'b0, 1'b0, 4'h0);
        check_route("R3 low alias read", 4'b1000);
        access(32'h000E_FFFF, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R9 below low window", 4'b0100);
    endtask

    task automatic t_shadow_rw();
        set_attr(4'b0011);
        access(32'h000F_8000, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R5 shadow read", 4'b0100);
        access(32'h000F_8000, 1'b1, 1'b1, 1'b0, 4'h0);
        check_route("R5 shadow write", 4'b0110);
        access(32'hFFFF_FFF0, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R5 top still rom", 4'b1000);
    endtask

    task automatic t_read_only();
        set_attr(4'b0101);
        access(32'h000F_0040, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R6 ro read", 4'b0100);
        access(32'h000F_0040, 1'b1, 1'b1, 1'b0, 4'h0);
        check_route("R6 ro write blocked", 4'b0001);
        @(posedge clk); #1;
        check_route("R8 block lasts one cycle", 4'b0000);
        set_attr(4'b0111);
        access(32'h000F_FFFF, 1'b1, 1'b1, 1'b0, 4'h0);
        check_route("R6 mode 11 write blocked", 4'b0001);
    endtask

    task automatic t_wprot();
        set_attr(4'b1011);
        access(32'h000F_0200, 1'b1, 1'b1, 1'b0, 4'h0);
        check_route("R7 protect mode01 write", 4'b0001);
        access(32'h000F_0200, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R7 protect mode01 read", 4'b0100);
        set_attr(4'b1001);
        access(32'h000F_0200, 1'b1, 1'b1, 1'b0, 4'h0);
        check_route("R7 protect ignored in copy", 4'b0110);
    endtask

    task automatic t_other();
        access(32'h1234_5678, 1'b1, 1'b1, 1'b0, 4'h0);
        check_route("R9 plain write", 4'b0110);
        access(32'h8000_0000, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R9 plain read", 4'b0100);
    endtask

    task automatic t_cfg_timing();
        set_attr(4'b0000);
        access(32'h000F_0000, 1'b0, 1'b1, 1'b1, 4'b0001);
        check_route("R10 same edge uses old attr", 4'b0100);
        access(32'h000F_0000, 1'b0, 1'b1, 1'b0, 4'h0);
        check_route("R10 next access uses new attr", 4'b1000);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
        a20_en = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_top_rom();
        t_a20();
        t_copy();
        t_shadow_rw();
        t_read_only();
        t_wprot();
        t_other();
        t_cfg_timing();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule